// File: doc/BRIEF.md
# PHY Management Command Engine

This block is a management master for Ethernet PHY registers. The host controls it through one 32-bit control word. A single write to that word holds the whole transaction: an opcode, a 5-bit PHY address, a 5-bit register number and, for a write, 16 bits of data. After the write, the engine sends one clause-22 management frame on the MDC/MDIO pair. When the frame ends, it sets a ready bit inside the same word. The host polls that bit.

For a read, the engine releases MDIO for the turnaround and the data phase. It samples the PHY's 16 data bits on MDC rising edges and returns them in the low half of the control word. Each completed frame also sets a sticky interrupt flag, which stays set until the host acknowledges it. MDC comes from the system clock through a parameterised half-period divider. MDC runs only while a frame is in progress.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, `ctrl_rdata` reads 32'h1000_0000 (only the ready bit set), and `mdc`, `mdio_oe` and `mgmt_irq` are all low.
- R2: Control word layout, for both writes and read-back. Bit 28 is ready. Bits 27:26 are the opcode (2'b10 is a read, 2'b01 is a write). Bits 25:21 are the PHY address and bits 20:16 are the register number. Bits 15:0 are data. Bits 31:29 read as zero. An accepted command word reads back with its opcode, address and register fields unchanged.
- R3: An accepted write carrying a valid opcode clears ready on the next clock and starts a frame. Ready returns to 1 when that frame has ended.
- R4: A frame is 64 MDC periods, sent MSB first and in this order: 32 preamble ones, start bits 01, the opcode, the PHY address, the register number, two turnaround bits and 16 data bits. On a write, the turnaround is driven as 1 then 0, and the data bits are the low 16 bits of the command word.
- R5: On a read, `mdio_oe` is low for bit positions 46 to 63 (counting the first preamble bit as 0). The bits sampled on the MDC rising edges of positions 48 to 63 appear in `ctrl_rdata[15:0]` once ready is set, first bit in bit 15.
- R6: While a frame runs, MDC stays high for DIV_HALF system clocks and then low for DIV_HALF system clocks. MDIO changes only while MDC is low. When no frame is running, MDC is low and `mdio_oe` is low. The default DIV_HALF of 25 gives 2.5 MHz from a 125 MHz clock.
- R7: A command word with opcode 2'b00 or 2'b11 is stored, but ready stays 1. It produces no MDC edge and does not set `mgmt_irq`.
- R8: A command word written while a frame is in progress is ignored. The running frame and the stored fields are unchanged.
- R9: `mgmt_irq` goes high on the same clock on which ready returns after a valid frame. It stays high until `irq_ack`. If completion and `irq_ack` occur together, completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Write strobe for the control word |
| host_wdata | input | 32 | Command word being written |
| irq_ack | input | 1 | Clears the completion flag |
| mdio_i | input | 1 | MDIO level as seen at the pad |
| ctrl_rdata | output | 32 | Current control word |
| mgmt_irq | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench runs a read and a write to every PHY address, each with a different register number. A small responder captures every MDC rising edge. The bench rebuilds each frame arithmetically and compares it bit by bit, along with the output-enable pattern. This catches a field placed at the wrong offset or a turnaround that is driven on a read. It also catches a data word shifted by one position, which is what an off-by-one sample window would produce.

Several targeted cases cover the other rules:
- A second command issued mid-frame must leave both the wire and the stored fields untouched. A design that accepts it would corrupt the frame.
- Opcodes 00 and 11 must produce no clock edges. A design that treats them as valid would start a frame.
- MDC phase lengths are measured on every edge, and the bench flags any MDIO change while MDC is high. A design that shifts data on the wrong edge would be caught here.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;

  typedef enum logic [1:0] {
    OP_RSV0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSV3  = 2'b11
  } mgmt_op_e;

  typedef struct packed {
    logic [1:0]        op;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;

  function automatic logic op_is_valid(input logic [1:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  function automatic logic op_is_read(input logic [1:0] op);
    return op == OP_READ;
  endfunction

  // Whole frame, first bit on the wire in bit 63.
  function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c);
    logic [1:0]        ta;
    logic [DATA_W-1:0] d;
    ta = op_is_read(c.op) ? 2'b11 : 2'b10;
    d  = op_is_read(c.op) ? '0 : c.data;
    return {32'hFFFF_FFFF, 2'b01, c.op, c.phy, c.regn, ta, d};
  endfunction

  // Output enable for the bit at position idx (0 = first preamble bit).
  function automatic logic drive_bit(input logic rd, input int unsigned idx);
    return !(rd && idx >= TA_POS);
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_evt = wrap && !mdc_q;
  assign fall_evt = wrap && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: every MDC rising edge comes from a rise event of the divider
  assert_mdc_rise_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(rise_evt));

  // R6: the clock stops low when the frame engine is not running
  assert_mdc_stops_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mgmt_cmd_t         cmd,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic                  rd_q;
  logic                  last_bit;
  logic                  sample_now;
  logic [IDX_W-1:0]      idx_next;

  assign last_bit   = (idx == IDX_W'(FRAME_BITS - 1));
  assign sample_now = active && rd_q && rise_evt && (idx >= IDX_W'(DATA_POS));
  assign idx_next   = idx + 1'b1;
  assign mdio_o     = shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      active  <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        shreg   <= build_frame(cmd);
        idx     <= '0;
        rd_q    <= op_is_read(cmd.op);
        active  <= 1'b1;
        mdio_oe <= 1'b1;
      end else if (active && fall_evt) begin
        if (last_bit) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx     <= idx_next;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          mdio_oe <= drive_bit(rd_q, int'(idx_next));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (start && !active) begin
      rdata <= '0;
    end else if (sample_now) begin
      rdata <= {rdata[DATA_W-2:0], mdio_i};
    end
  end

  // R5: the PHY owns the line during turnaround and data of a read
  assert_release_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_q && idx >= IDX_W'(TA_POS)) |-> !mdio_oe);

  // R4: a frame ends only after its final bit position
  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last_bit) && !active);

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  input  logic        irq_ack,
  input  logic        mdio_i,
  output logic [31:0] ctrl_rdata,
  output logic        mgmt_irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int READY_BIT = 28;

  mgmt_cmd_t         cmd_q;
  mgmt_cmd_t         cmd_in;
  logic              ready_q;
  logic              busy_q;
  logic              irq_q;
  logic              accept;
  logic              start;
  logic              frame_done;
  logic              frame_active;
  logic              rise_evt;
  logic              fall_evt;
  logic [DATA_W-1:0] frame_rdata;

  assign cmd_in = mgmt_cmd_t'(host_wdata[27:0]);
  assign accept = host_wr && !busy_q;
  assign start  = accept && op_is_valid(cmd_in.op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ready_q <= 1'b1;
      busy_q  <= 1'b0;
    end else if (accept) begin
      cmd_q   <= cmd_in;
      ready_q <= !op_is_valid(cmd_in.op);
      busy_q  <= op_is_valid(cmd_in.op);
    end else if (frame_done) begin
      ready_q <= 1'b1;
      busy_q  <= 1'b0;
      if (op_is_read(cmd_q.op)) cmd_q.data <= frame_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq_q <= 1'b0;
    else if (frame_done) irq_q <= 1'b1;
    else if (irq_ack)    irq_q <= 1'b0;
  end

  assign ctrl_rdata = {3'b000, ready_q, cmd_q};
  assign mgmt_irq   = irq_q;

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_clkdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (frame_active),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd_in),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .active   (frame_active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (frame_rdata),
    .done     (frame_done)
  );

  // R3: a valid command drops ready on the next clock
  assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ctrl_rdata[READY_BIT]);

  // R6: the bus is quiet whenever no command is pending
  assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  // R6: MDIO holds while MDC stays high
  assert_mdio_hold_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R7: reserved opcodes leave the engine idle and ready
  assert_invalid_no_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !op_is_valid(cmd_in.op)) |=> (!frame_active && ctrl_rdata[READY_BIT]));

  // R8: writes during a frame do not touch the stored fields
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && busy_q) |=> $stable(ctrl_rdata[27:16]));

  // R9: completion raises the flag
  assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> mgmt_irq);

endmodule

// File: tb/mdio_cmd_engine_bench.sv
module mdio_cmd_engine_bench;
  localparam int DH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        irq_ack = 1'b0;
  logic        mdio_i = 1'b1;
  logic [31:0] ctrl_rdata;
  logic        mgmt_irq, mdc, mdio_o, mdio_oe;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_cmd_engine #(.DIV_HALF(DH)) u_mdio_cmd_engine (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .irq_ack(irq_ack), .mdio_i(mdio_i), .ctrl_rdata(ctrl_rdata),
    .mgmt_irq(mgmt_irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  // PHY responder and wire monitor
  logic [63:0] cap, oecap;
  int          pidx = 0;
  logic [15:0] rdpat = '0;
  int          last_rise = 0, period_err = 0, high_err = 0, edge_err = 0;
  logic        prev_o = 1'b0, prev_mdc = 1'b0;

  always @(posedge mdc) begin
    if (pidx > 0 && cyc - last_rise != 2 * DH) period_err++;
    last_rise = cyc;
    if (pidx < 64) begin
      cap[63 - pidx]   = mdio_o;
      oecap[63 - pidx] = mdio_oe;
    end
    pidx++;
  end

  always @(negedge mdc) begin
    if (cyc - last_rise != DH) high_err++;
    if (pidx >= 48 && pidx < 64) mdio_i = rdpat[63 - pidx];
    else if (pidx == 47)         mdio_i = 1'b0;
    else                         mdio_i = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && mdc && prev_mdc && mdio_o != prev_o) edge_err++;
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] wd);
    logic [63:0] f;
    f = '1;
    f[31:30] = 2'b01;
    f[29:28] = op;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = 2'b10;
    f[15:0]  = wd;
    return f;
  endfunction

  function automatic logic [15:0] pattern(input logic [4:0] phy, input logic [4:0] rg);
    logic [5:0] s;
    s = 6'(phy * 3 + rg);
    return {rg, phy, s};
  endfunction

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ctrl_rdata[28] && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ack_irq();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd);
    logic [63:0] ef, eoe;
    bit rd;
    rd = (op == 2'b10);
    pidx = 0;
    rdpat = pattern(phy, rg);
    write_word({4'b0000, op, phy, rg, wd});
    check(ctrl_rdata[28] == 1'b0, "R3 ready cleared", 64'(ctrl_rdata[28]), 64'd0);
    wait_ready();
    check(ctrl_rdata[28] == 1'b1, "R3 ready returns", 64'(ctrl_rdata[28]), 64'd1);
    ef  = exp_frame(op, phy, rg, wd);
    eoe = rd ? {{46{1'b1}}, 18'b0} : '1;
    if (rd)
      check(cap[63:18] == ef[63:18], "R4 read header", cap, ef);
    else
      check(cap == ef, "R4 write frame", cap, ef);
    check(oecap == eoe, "R5 output enable pattern", oecap, eoe);
    if (rd)
      check(ctrl_rdata[15:0] == rdpat, "R5 read data", 64'(ctrl_rdata[15:0]), 64'(rdpat));
    check(ctrl_rdata == {3'b000, 1'b1, op, phy, rg, rd ? rdpat : wd}, "R2 readback",
          64'(ctrl_rdata), 64'({3'b000, 1'b1, op, phy, rg, rd ? rdpat : wd}));
    check(mgmt_irq == 1'b1, "R9 irq on done", 64'(mgmt_irq), 64'd1);
    ack_irq();
    check(mgmt_irq == 1'b0, "R9 irq cleared", 64'(mgmt_irq), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctrl_rdata == 32'h1000_0000, "R1 reset word", 64'(ctrl_rdata), 64'h1000_0000);
    check(!mdc && !mdio_oe && !mgmt_irq, "R1 reset outputs", 64'({mdc, mdio_oe, mgmt_irq}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R5: sweep all PHY addresses, both directions
    for (int p = 0; p < 32; p++) begin
      run_cmd(2'b01, 5'(p), 5'(31 - p), 16'(16'hA5C3 ^ (p * 16'h0109)));
      run_cmd(2'b10, 5'(p), 5'((p * 7) % 32), 16'hFFFF);
    end
    check(period_err == 0, "R6 MDC period", 64'(period_err), 64'd0);
    check(high_err == 0, "R6 MDC high phase", 64'(high_err), 64'd0);
    check(edge_err == 0, "R6 MDIO stable while MDC high", 64'(edge_err), 64'd0);

    // R7 reserved opcodes
    for (int k = 0; k < 2; k++) begin
      logic [1:0] bad;
      bad = (k == 0) ? 2'b00 : 2'b11;
      pidx = 0;
      write_word({4'b0000, bad, 5'd9, 5'd4, 16'h1234});
      check(ctrl_rdata[28] == 1'b1, "R7 ready stays set", 64'(ctrl_rdata[28]), 64'd1);
      repeat (40) @(negedge clk);
      check(pidx == 0, "R7 no MDC edges", 64'(pidx), 64'd0);
      check(mgmt_irq == 1'b0, "R7 no irq", 64'(mgmt_irq), 64'd0);
      check(ctrl_rdata[27:0] == {bad, 5'd9, 5'd4, 16'h1234}, "R7 fields stored",
            64'(ctrl_rdata[27:0]), 64'({bad, 5'd9, 5'd4, 16'h1234}));
    end

    // R8 write during a frame is ignored
    pidx = 0;
    write_word({4'b0000, 2'b01, 5'd3, 5'd17, 16'hBEEF});
    repeat (60) @(negedge clk);
    write_word({4'b0000, 2'b10, 5'd30, 5'd2, 16'h0000});
    check(ctrl_rdata[28] == 1'b0, "R8 still busy", 64'(ctrl_rdata[28]), 64'd0);
    wait_ready();
    check(cap == exp_frame(2'b01, 5'd3, 5'd17, 16'hBEEF), "R8 frame unchanged", cap,
          exp_frame(2'b01, 5'd3, 5'd17, 16'hBEEF));
    check(ctrl_rdata[27:0] == {2'b01, 5'd3, 5'd17, 16'hBEEF}, "R8 fields unchanged",
          64'(ctrl_rdata[27:0]), 64'({2'b01, 5'd3, 5'd17, 16'hBEEF}));

    // R9 flag holds without acknowledge
    repeat (20) @(negedge clk);
    check(mgmt_irq == 1'b1, "R9 irq held", 64'(mgmt_irq), 64'd1);
    ack_irq();
    check(mgmt_irq == 1'b0, "R9 irq acked", 64'(mgmt_irq), 64'd0);
    check(!mdc && !mdio_oe, "R6 idle bus", 64'({mdc, mdio_oe}), 64'd0);

    finish_run();
  end

endmodule